// File: doc/BRIEF.md
# Command Packet Assembler

This block sits between a 32-bit command word stream and a downstream drawing engine. It groups the incoming words into packets whose length depends on the first word: the top byte of a header word is an opcode, and a fixed opcode-to-length table says how many more words belong to the same packet. When the last word of a packet arrives, the whole packet (up to twelve words) is presented on a valid/ready dispatch port together with its word count.

A side input marks an active image-load transfer. While it is high, the command words are not parsed. They pass straight to a pixel-write port that has its own handshake. A partly assembled packet is left untouched and continues once the transfer ends. An abort input drops a partly assembled packet, so that the next accepted word is treated as a header. A packet that is already waiting for dispatch is not lost. The block never drops a word. If a finished packet cannot leave, the input is stalled.

Top module: `cmd_packet_assembler`

## Requirements
- R1: The opcode is bits 31:24 of a header word. A dispatched packet carries `pkt_len` = 1 + the number of extra words the opcode calls for. Word k of the packet (k = 0 is the header) appears on `pkt_words[32k+31:32k]`.
- R2: Extra-word counts for opcodes 0x20–0x3F, in groups of four consecutive opcodes starting at 0x20, are 3, 6, 4, 8, 5, 8, 7, 11.
- R3: Extra-word counts for the other opcodes are as follows. 0x02 takes 2 and 0x80 takes 3. 0xA0 and 0xC0 take 2 each. In groups of four starting at 0x40, opcodes 0x40–0x5F take 2, 0, 3, 3, 3, 0, 4, 4. In groups of four starting at 0x60, opcodes 0x60–0x7F take 2, 3, 1, 2, 1, 2, 1, 2. Every other opcode takes 0.
- R4: A header whose opcode takes 0 extra words becomes a one-word packet. `pkt_valid` is high in the cycle after that header is accepted.
- R5: For longer packets, `pkt_valid` rises in the cycle after the word that completes the packet is accepted.
- R6: The first word accepted after a packet is complete is treated as a new header.
- R7: Assume the image-load input is low. While `pkt_valid` is high and `pkt_ready` is low, `in_ready` is low, and `pkt_valid`, `pkt_len` and `pkt_words` hold steady. No input word is lost.
- R8: While `img_active` is high, `pix_valid` follows `in_valid`, `pix_data` follows `in_data`, and `in_ready` follows `pix_ready`. The packet being assembled is not changed, and it resumes with its next word once `img_active` goes low.
- R9: In a cycle where `abort` is high and `img_active` is low, `in_ready` is low. The packet being assembled is discarded, so the next accepted word is a header. A packet already waiting for dispatch is still delivered.
- R10: After reset, `pkt_valid` is low, `in_ready` is high, and the first accepted word is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word taken this cycle when high with in_valid |
| img_active | input | 1 | Image-load transfer in progress; words go to the pixel port |
| abort | input | 1 | Discard the partly assembled packet |
| pix_valid | output | 1 | Pixel word offered |
| pix_data | output | 32 | Pixel word |
| pix_ready | input | 1 | Pixel sink accepts |
| pkt_valid | output | 1 | Complete packet offered |
| pkt_ready | input | 1 | Drawing engine accepts the packet |
| pkt_len | output | 4 | Word count of the packet, 1 to 12 |
| pkt_words | output | 384 | Packet words, word k at bits 32k+31:32k |

## Verification
The bench sends headers with every opcode group of the length table. These include one-word opcodes, the two-word and three-word special codes, and the twelve-word maximum, so each table entry can be told apart by the dispatch cycle and the word count. The same traffic is then repeated with a pseudo-random `pkt_ready`. This shows that a stalled dispatch holds its contents and that the input waits rather than losing words. An image-load burst placed inside a half-built packet checks that the bypass leaves the parser untouched. Aborts given mid-packet and during a pending dispatch check that only the unfinished packet is discarded.

// File: rtl/cpa_pkg.sv
// Package: shared types and the opcode length rule for the packet assembler.
// Assumes the opcode is a full byte; the rule returns extra words after the header.
package cpa_pkg;

    localparam int OP_W = 8;

    // Extra words following a header, computed from opcode groups of four.
    function automatic logic [3:0] extra_words(input logic [OP_W-1:0] op);
        logic [3:0] n;
        n = 4'd0;
        case (op[7:5])
            3'b000: n = (op == 8'h02) ? 4'd2 : 4'd0;
            3'b001: begin
                case (op[4:2])
                    3'd0: n = 4'd3;
                    3'd1: n = 4'd6;
                    3'd2: n = 4'd4;
                    3'd3: n = 4'd8;
                    3'd4: n = 4'd5;
                    3'd5: n = 4'd8;
                    3'd6: n = 4'd7;
                    default: n = 4'd11;
                endcase
            end
            3'b010: begin
                case (op[4:2])
                    3'd0: n = 4'd2;
                    3'd1, 3'd5: n = 4'd0;
                    3'd2, 3'd3, 3'd4: n = 4'd3;
                    default: n = 4'd4;
                endcase
            end
            3'b011: begin
                case (op[4:2])
                    3'd0: n = 4'd2;
                    3'd1: n = 4'd3;
                    3'd2, 3'd4, 3'd6: n = 4'd1;
                    default: n = 4'd2;
                endcase
            end
            3'b100: n = (op == 8'h80) ? 4'd3 : 4'd0;
            3'b101: n = (op == 8'hA0) ? 4'd2 : 4'd0;
            3'b110: n = (op == 8'hC0) ? 4'd2 : 4'd0;
            default: n = 4'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cpa_len_lut.sv
// Module: opcode-to-length table. Builds one constant entry per opcode with a
// generate loop and returns the extra-word count for the presented opcode.
// Assumes LEN_W is wide enough for the largest entry (11).
module cpa_len_lut
    import cpa_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic [OP_W-1:0]  op,
    output logic [LEN_W-1:0] extra
);
    localparam int ENTRIES = 1 << OP_W;

    logic [LEN_W-1:0] table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // One constant entry per opcode value.
        assign table_q[g] = LEN_W'(extra_words(OP_W'(g)));
    end

    // Index the table by the header opcode.
    assign extra = table_q[op];

endmodule

// File: rtl/cpa_word_buffer.sv
// Module: packet word store. One register per packet slot, written by index,
// presented flat as the packet bus. Assumes wr_idx < MAX_WORDS when wr_en.
module cpa_word_buffer #(
    parameter int DATA_W    = 32,
    parameter int MAX_WORDS = 12,
    parameter int IDX_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [MAX_WORDS*DATA_W-1:0] words
);
    logic [DATA_W-1:0] slot_q [MAX_WORDS];

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        // Capture the incoming word into its slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                slot_q[g] <= wr_data;
        end
        assign words[g*DATA_W +: DATA_W] = slot_q[g];
    end

endmodule

// File: rtl/cpa_parser_ctrl.sv
// Module: packet sequencer. Tracks words still owed to the current packet,
// picks the write slot, raises the dispatch flag and stalls the input while a
// dispatch is refused. Assumes hdr_extra reflects the word currently offered.
module cpa_parser_ctrl #(
    parameter int MAX_WORDS = 12,
    parameter int LEN_W     = 4,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             img_active,
    input  logic             abort,
    input  logic [LEN_W-1:0] hdr_extra,
    input  logic             pkt_ready,
    output logic             par_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             pkt_valid,
    output logic [LEN_W-1:0] pkt_len
);
    logic [LEN_W-1:0] rem_q;
    logic [IDX_W-1:0] idx_q;
    logic             vld_q;
    logic [LEN_W-1:0] len_q;
    logic             accept;
    logic             at_header;

    // Parser may take a word when no abort and no refused dispatch.
    assign par_ready = !abort && (!vld_q || pkt_ready);
    assign accept    = in_valid && par_ready && !img_active;
    assign at_header = (rem_q == '0);
    assign wr_en     = accept;
    assign wr_idx    = at_header ? '0 : idx_q;
    assign pkt_valid = vld_q;
    assign pkt_len   = len_q;

    // Count remaining words, advance slot index, raise and retire dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            idx_q <= '0;
            vld_q <= 1'b0;
            len_q <= '0;
        end else begin
            if (vld_q && pkt_ready)
                vld_q <= 1'b0;
            if (abort && !img_active) begin
                rem_q <= '0;
                idx_q <= '0;
            end else if (accept) begin
                if (at_header) begin
                    if (hdr_extra == '0) begin
                        vld_q <= 1'b1;
                        len_q <= LEN_W'(1);
                        idx_q <= '0;
                    end else begin
                        rem_q <= hdr_extra;
                        idx_q <= IDX_W'(1);
                    end
                end else begin
                    rem_q <= rem_q - LEN_W'(1);
                    if (rem_q == LEN_W'(1)) begin
                        vld_q <= 1'b1;
                        len_q <= LEN_W'(idx_q) + LEN_W'(1);
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
            end
        end
    end

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !pkt_ready) |-> !accept);                                   // R7
    AST_STALL_HOLDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !pkt_ready) |=> (vld_q && $stable(len_q)));                 // R7
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !img_active) |=> (rem_q == '0));                            // R9
    AST_BYPASS_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        img_active |=> ($stable(rem_q) && $stable(idx_q)));                   // R8
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (len_q >= LEN_W'(1) && len_q <= LEN_W'(MAX_WORDS)));        // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && at_header) |-> (hdr_extra < LEN_W'(MAX_WORDS)));           // R2

endmodule

// File: rtl/cmd_packet_assembler.sv
// Module: command packet assembler top. Routes words to the pixel port during
// an image load, otherwise builds opcode-sized packets and offers them on the
// dispatch port. Assumes the image-load flag changes only between words.
module cmd_packet_assembler
    import cpa_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MAX_WORDS = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    output logic                        in_ready,
    input  logic                        img_active,
    input  logic                        abort,
    output logic                        pix_valid,
    output logic [DATA_W-1:0]           pix_data,
    input  logic                        pix_ready,
    output logic                        pkt_valid,
    input  logic                        pkt_ready,
    output logic [$clog2(MAX_WORDS+1)-1:0] pkt_len,
    output logic [MAX_WORDS*DATA_W-1:0] pkt_words
);
    localparam int LEN_W = $clog2(MAX_WORDS + 1);
    localparam int IDX_W = $clog2(MAX_WORDS);

    logic [LEN_W-1:0] hdr_extra;
    logic             par_ready;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    // Steer the handshake to the pixel sink or the parser.
    assign in_ready  = img_active ? pix_ready : par_ready;
    assign pix_valid = img_active && in_valid;
    assign pix_data  = in_data;

    cpa_len_lut #(.LEN_W(LEN_W)) u_lut (
        .op    (in_data[DATA_W-1 -: OP_W]),
        .extra (hdr_extra)
    );

    cpa_parser_ctrl #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .img_active (img_active),
        .abort      (abort),
        .hdr_extra  (hdr_extra),
        .pkt_ready  (pkt_ready),
        .par_ready  (par_ready),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .pkt_valid  (pkt_valid),
        .pkt_len    (pkt_len)
    );

    cpa_word_buffer #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (in_data),
        .words   (pkt_words)
    );

    AST_PKT_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> $stable(pkt_words));                    // R7
    AST_PIX_NO_PARSE: assert property (@(posedge clk) disable iff (!rst_n)
        (img_active && in_valid && pix_ready) |-> in_ready);                  // R8
    AST_ABORT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !img_active) |-> !in_ready);                                // R9

endmodule

// File: tb/cmd_packet_assembler_tb.sv
module cmd_packet_assembler_tb;
    localparam int DW = 32;
    localparam int MW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready;
    logic img_active = 1'b0;
    logic abort = 1'b0;
    logic pix_valid;
    logic [DW-1:0] pix_data;
    logic pix_ready = 1'b1;
    logic pkt_valid;
    logic pkt_ready = 1'b1;
    logic [3:0] pkt_len;
    logic [MW*DW-1:0] pkt_words;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string phase = "R10";
    int rdy_mode = 0;
    int pix_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    // reference model state
    int m_rem = 0;
    int m_idx = 0;
    bit m_vld = 0;
    int m_len = 0;
    logic [DW-1:0] m_buf [MW];
    logic [DW-1:0] m_out [MW];

    always #10 clk = ~clk;

    cmd_packet_assembler u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .img_active(img_active), .abort(abort),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
        .pkt_words(pkt_words)
    );

    function automatic int ref_extra(input logic [7:0] op);
        case (op) inside
            8'h02, 8'hA0, 8'hC0: return 2;
            8'h80: return 3;
            [8'h20:8'h23]: return 3;
            [8'h24:8'h27]: return 6;
            [8'h28:8'h2B]: return 4;
            [8'h2C:8'h2F]: return 8;
            [8'h30:8'h33]: return 5;
            [8'h34:8'h37]: return 8;
            [8'h38:8'h3B]: return 7;
            [8'h3C:8'h3F]: return 11;
            [8'h40:8'h43]: return 2;
            [8'h48:8'h53]: return 3;
            [8'h58:8'h5F]: return 4;
            [8'h60:8'h63]: return 2;
            [8'h64:8'h67]: return 3;
            [8'h68:8'h6B], [8'h70:8'h73], [8'h78:8'h7B]: return 1;
            [8'h6C:8'h6F], [8'h74:8'h77], [8'h7C:8'h7F]: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_ready();
        if (img_active) return pix_ready;
        return !abort && (!m_vld || pkt_ready);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) %s: actual=%0h expected=%0h", req, phase, what, act, exp);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_idx = 0; m_vld = 0; m_len = 0;
        end else begin
            bit acc;
            int ex;
            acc = in_valid && exp_ready() && !img_active;
            if (m_vld && pkt_ready) m_vld = 0;
            if (abort && !img_active) begin
                m_rem = 0; m_idx = 0;
            end else if (acc) begin
                if (m_rem == 0) begin
                    m_buf[0] = in_data;
                    ex = ref_extra(in_data[31:24]);
                    if (ex == 0) begin
                        m_vld = 1; m_len = 1; m_out[0] = in_data;
                    end else begin
                        m_rem = ex; m_idx = 1;
                    end
                end else begin
                    m_buf[m_idx] = in_data;
                    m_rem--;
                    if (m_rem == 0) begin
                        m_vld = 1; m_len = m_idx + 1;
                        for (int k = 0; k < MW; k++) m_out[k] = m_buf[k];
                        m_idx = 0;
                    end else m_idx++;
                end
            end
        end
    end

    // Drive ready inputs and compare against the model every cycle.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pkt_ready <= (rdy_mode == 0) ? 1'b1 : lfsr[3];
        pix_ready <= (pix_mode == 0) ? 1'b1 : lfsr[7];
        #5;
        if (rst_n && !done) begin
            if (img_active) begin
                chk("R8", "in_ready", in_ready, exp_ready());
                chk("R8", "pix_valid", pix_valid, in_valid);
                chk("R8", "pix_data", pix_data, in_data);
            end else if (abort) chk("R9", "in_ready", in_ready, exp_ready());
            else if (m_vld && !pkt_ready) chk("R7", "in_ready", in_ready, exp_ready());
            else chk("R6", "in_ready", in_ready, exp_ready());
            chk("R5", "pkt_valid", pkt_valid, m_vld);
            if (m_vld && pkt_valid) begin
                chk("R1", "pkt_len", pkt_len, m_len);
                for (int k = 0; k < m_len && k < MW; k++)
                    chk("R1", "pkt_word", pkt_words[k*DW +: DW], m_out[k]);
            end
        end
    end

    task automatic send(input logic [DW-1:0] w);
        bit got;
        got = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data = w;
        while (!got) begin
            #8 got = in_ready;
            @(posedge clk);
            if (!got) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic packet(input logic [7:0] op, input int tag);
        int ex;
        ex = ref_extra(op);
        send({op, 8'h00, 16'(tag)});
        for (int k = 1; k <= ex; k++) send({8'hF0, 8'(k), 16'(tag)});
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        abort = 1'b1; in_valid = 1'b1; in_data = 32'h2C00_DEAD;
        @(negedge clk);
        abort = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #6;
        phase = "R10";
        chk("R10", "reset pkt_valid", pkt_valid, 0);
        chk("R10", "reset in_ready", in_ready, 1);

        phase = "R4";
        packet(8'h00, 1); packet(8'hE1, 2); packet(8'h44, 3); packet(8'h57, 4);
        idle(2);
        phase = "R3";
        packet(8'h02, 5); packet(8'h80, 6); packet(8'hA0, 7); packet(8'hC0, 8);
        packet(8'h81, 9); packet(8'hA1, 10);
        for (int op = 8'h40; op < 8'h80; op += 4) packet(8'(op + 1), op);
        idle(2);
        phase = "R2";
        for (int op = 8'h20; op < 8'h40; op += 4) packet(8'(op + 3), op);
        idle(2);
        phase = "R6";
        packet(8'h3C, 40); packet(8'h00, 41); packet(8'h3F, 42);
        idle(2);

        phase = "R7";
        rdy_mode = 1;
        for (int op = 8'h20; op < 8'h80; op += 4) packet(8'(op), op + 100);
        packet(8'h01, 1); packet(8'h02, 2); packet(8'h03, 3);
        idle(6);
        rdy_mode = 0;

        phase = "R8";
        send(32'h2800_0001); send(32'hF001_0001);
        idle(1);
        pix_mode = 1;
        @(negedge clk); img_active = 1'b1;
        for (int k = 0; k < 6; k++) send(32'h5A5A_0000 + k);
        @(negedge clk); in_valid = 1'b0; img_active = 1'b0;
        pix_mode = 0;
        send(32'hF002_0001); send(32'hF003_0001); send(32'hF004_0001);
        idle(2);

        phase = "R9";
        send(32'h3400_0009); send(32'hF001_0009);
        pulse_abort();
        packet(8'h20, 11);
        idle(1);
        rdy_mode = 2;
        pkt_ready = 1'b0;
        send(32'h6000_0012); send(32'hF001_0012); send(32'hF002_0012);
        send(32'h2400_0013);
        pulse_abort();
        rdy_mode = 0;
        packet(8'h68, 14);
        idle(4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule